// File: doc/BRIEF.md
# Configurable Logic Output Cell

This block is one output cell of a programmable logic block. A logic term enters through a selectable inverter, which is an XOR against a configuration bit. The cell can also take its data straight from a pad input instead, which turns the cell into an input register. The data is held in a storage element that works as a D flip-flop, a T flip-flop or a transparent latch. The cell drives out either the stored value or, in bypass, the combinational XOR result.

The storage element is timed by one of eight clock sources, chosen by a configuration code:

- four block clocks;
- a shared term clock;
- an individual term clock in true form;
- the same term clock in inverted form;
- a constant zero, which switches the clock off.

All clock sources are treated as level signals and sampled by the system clock `clk`. A rising edge of the selected source, seen between two system-clock samples, is the event that updates a flip-flop.

A single individual term serves one of two roles, set by a configuration bit: it is either a clock enable or an initialization request. Initialization can also come from a shared term, when that term is enabled, and from power-up reset. A configuration bit decides whether initialization presets the cell to 1 or resets it to 0. Initialization overrides the cell output at once and takes priority over the clock and the clock enable.

Top module: `logic_out_cell`

## Requirements
- R1: While `rst` is high, after a `clk` rising edge and with bypass off, `cell_q` equals `cfg_preset`; the sampled clock history is cleared to 0.
- R2: The logic data value is `logic_in` XOR `cfg_invert`.
- R3: With `cfg_mode` 0 (or 3) the cell is a D flip-flop. On a rising event of the selected source with the enable active, it loads the data value. The new value appears at `cell_q` after that `clk` edge.
- R4: With `cfg_mode` 1 the cell is a T flip-flop. On a rising event with the enable active, it inverts its state when the data value is 1 and holds its state when the data value is 0.
- R5: With `cfg_mode` 2 the cell is a latch. While the selected source is high and the enable is active, `cell_q` follows the data value in the same cycle. Otherwise the cell holds the last value passed.
- R6: `cfg_clk_sel` selects the source as follows. Codes 0 to 3 select `blk_clk[code]`. Code 4 selects `shared_clk`. Code 5 selects `term_clk`. Code 6 selects the inverse of `term_clk`. Code 7 selects a constant 0, so with code 7 the cell never updates except by initialization.
- R7: A rising event is a `clk` edge at which the selected source is 1 and the selected source was 0 at the previous `clk` edge.
- R8: While an initialization request is active and bypass is off, `cell_q` equals `cfg_preset` in the same cycle. The stored state is loaded with `cfg_preset`, whatever the clock and the enable are doing.
- R9: An initialization request is active when `shared_init` is 1 with `cfg_shared_init_en` set, or when `term_pt` is 1 with `cfg_term_is_ce` clear.
- R10: With `cfg_term_is_ce` set, `term_pt` is the clock enable. While `term_pt` is 0, neither a flip-flop nor a latch changes.
- R11: With `cfg_pad_sel` set, the stored data value is `pad_in`, and the XOR is not applied.
- R12: With `cfg_bypass` set, `cell_q` equals `logic_in` XOR `cfg_invert` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all clock sources |
| rst | input | 1 | Synchronous active-high power-up initialization |
| blk_clk | input | NBLK (4) | Block clock sources |
| shared_clk | input | 1 | Shared term clock source |
| term_clk | input | 1 | Individual term clock, offered in both polarities |
| logic_in | input | 1 | Logic term from the product array |
| pad_in | input | 1 | Direct pad input for input-register use |
| shared_init | input | 1 | Shared initialization term |
| term_pt | input | 1 | Single term used as clock enable or as initialization |
| cfg_clk_sel | input | SEL_W (3) | Clock source code |
| cfg_mode | input | 2 | Storage mode: 0 D, 1 T, 2 latch, 3 D |
| cfg_invert | input | 1 | XOR polarity bit |
| cfg_pad_sel | input | 1 | Store the pad input instead of the XOR result |
| cfg_bypass | input | 1 | Output the XOR result instead of the stored value |
| cfg_preset | input | 1 | Initialization value: 1 presets, 0 resets |
| cfg_shared_init_en | input | 1 | Enable for the shared initialization term |
| cfg_term_is_ce | input | 1 | Role of `term_pt`: 1 clock enable, 0 initialization |
| cell_q | output | 1 | Cell output |

## Verification
The bypass result, the initialization override and latch transparency all reach `cell_q` combinationally, in the same cycle as the inputs that cause them. A flip-flop update becomes visible only after the `clk` edge at which the rising event is seen, and that event depends on the sample taken at the `clk` edge before it.

The bench drives every input at the falling edge of `clk` and samples `cell_q` one nanosecond later. Its model computes the output expected for that moment from its own state. It then advances that state across the next rising edge of `clk`, together with the previous-sample value of the selected source. In this way each result is compared in exactly the cycle in which it is due.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int NUM_BLK_CLK = 4;

    typedef enum logic [1:0] {
        ST_DFF     = 2'd0,
        ST_TFF     = 2'd1,
        ST_LATCH   = 2'd2,
        ST_DFF_ALT = 2'd3
    } store_mode_e;

    typedef struct packed {
        logic init_req;
        logic ce;
        logic store_d;
        logic xor_val;
    } cell_ctl_t;

    function automatic logic edge_next(store_mode_e mode, logic cur, logic d);
        if (mode == ST_TFF) return cur ^ d;
        return d;
    endfunction

endpackage

// File: rtl/lcell_clk_select.sv
module lcell_clk_select #(
    parameter int NBLK  = lcell_pkg::NUM_BLK_CLK,
    parameter int SEL_W = $clog2(NBLK + 4)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBLK-1:0]  blk_clk,
    input  logic             shared_clk,
    input  logic             term_clk,
    input  logic [SEL_W-1:0] sel,
    output logic             src_level,
    output logic             src_rise
);
    localparam int NPAD = 1 << SEL_W;
    localparam int NSRC = NBLK + 4;

    logic [NPAD-1:0] srcs;
    logic            prev_level;

    for (genvar j = 0; j < NPAD; j++) begin : g_src
        if (j < NBLK) begin : g_blk
            assign srcs[j] = blk_clk[j];
        end else if (j == NBLK) begin : g_shared
            assign srcs[j] = shared_clk;
        end else if (j == NBLK + 1) begin : g_true
            assign srcs[j] = term_clk;
        end else if (j == NBLK + 2) begin : g_comp
            assign srcs[j] = ~term_clk;
        end else begin : g_off
            assign srcs[j] = 1'b0;
        end
    end

    assign src_level = srcs[sel];

    always_ff @(posedge clk) begin
        if (rst) prev_level <= 1'b0;
        else     prev_level <= src_level;
    end

    assign src_rise = src_level & ~prev_level;

    // R6: the last code is the off setting, so it never produces a rising event
    a_r6_off_no_event: assert property (@(posedge clk) disable iff (rst)
        (int'(sel) >= NSRC - 1) |-> !src_rise);

endmodule

// File: rtl/lcell_ctl_decode.sv
module lcell_ctl_decode (
    input  logic                  logic_in,
    input  logic                  pad_in,
    input  logic                  shared_init,
    input  logic                  term_pt,
    input  logic                  cfg_invert,
    input  logic                  cfg_pad_sel,
    input  logic                  cfg_shared_init_en,
    input  logic                  cfg_term_is_ce,
    output lcell_pkg::cell_ctl_t  ctl
);
    always_comb begin
        ctl.xor_val  = logic_in ^ cfg_invert;
        ctl.store_d  = cfg_pad_sel ? pad_in : ctl.xor_val;
        ctl.init_req = (cfg_shared_init_en & shared_init) | (~cfg_term_is_ce & term_pt);
        ctl.ce       = cfg_term_is_ce ? term_pt : 1'b1;
    end

endmodule

// File: rtl/lcell_store.sv
module lcell_store (
    input  logic                   clk,
    input  logic                   rst,
    input  lcell_pkg::store_mode_e mode,
    input  logic                   preset,
    input  logic                   init_req,
    input  logic                   ce,
    input  logic                   rise,
    input  logic                   gate,
    input  logic                   d,
    output logic                   q_view
);
    import lcell_pkg::*;

    logic q_reg;
    logic is_latch;

    assign is_latch = (mode == ST_LATCH);

    always_ff @(posedge clk) begin
        if (rst)                     q_reg <= preset;
        else if (init_req)           q_reg <= preset;
        else if (is_latch) begin
            if (gate && ce)          q_reg <= d;
        end else if (rise && ce)     q_reg <= edge_next(mode, q_reg, d);
    end

    always_comb begin
        if (init_req)                       q_view = preset;
        else if (is_latch && gate && ce)    q_view = d;
        else                                q_view = q_reg;
    end

    // R3: D mode loads the data value on an enabled rising event
    a_r3_dff_load: assert property (@(posedge clk) disable iff (rst)
        (!init_req && ce && rise && (mode == ST_DFF)) |=> (q_reg == $past(d)));

    // R4: T mode toggles on data 1
    a_r4_tff_toggle: assert property (@(posedge clk) disable iff (rst)
        (!init_req && ce && rise && (mode == ST_TFF)) |=> (q_reg == ($past(q_reg) ^ $past(d))));

    // R10: without enable the state holds
    a_r10_hold_no_ce: assert property (@(posedge clk) disable iff (rst)
        (!init_req && !ce) |=> $stable(q_reg));

    // R8: initialization loads the preset value
    a_r8_init_load: assert property (@(posedge clk) disable iff (rst)
        init_req |=> (q_reg == $past(preset)));

endmodule

// File: rtl/logic_out_cell.sv
module logic_out_cell #(
    parameter int NBLK  = lcell_pkg::NUM_BLK_CLK,
    parameter int SEL_W = $clog2(NBLK + 4)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBLK-1:0]  blk_clk,
    input  logic             shared_clk,
    input  logic             term_clk,
    input  logic             logic_in,
    input  logic             pad_in,
    input  logic             shared_init,
    input  logic             term_pt,
    input  logic [SEL_W-1:0] cfg_clk_sel,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_invert,
    input  logic             cfg_pad_sel,
    input  logic             cfg_bypass,
    input  logic             cfg_preset,
    input  logic             cfg_shared_init_en,
    input  logic             cfg_term_is_ce,
    output logic             cell_q
);
    import lcell_pkg::*;

    cell_ctl_t ctl;
    logic      src_level;
    logic      src_rise;
    logic      q_view;

    lcell_clk_select #(.NBLK(NBLK), .SEL_W(SEL_W)) u_clk_sel (
        .clk        (clk),
        .rst        (rst),
        .blk_clk    (blk_clk),
        .shared_clk (shared_clk),
        .term_clk   (term_clk),
        .sel        (cfg_clk_sel),
        .src_level  (src_level),
        .src_rise   (src_rise)
    );

    lcell_ctl_decode u_decode (
        .logic_in           (logic_in),
        .pad_in             (pad_in),
        .shared_init        (shared_init),
        .term_pt            (term_pt),
        .cfg_invert         (cfg_invert),
        .cfg_pad_sel        (cfg_pad_sel),
        .cfg_shared_init_en (cfg_shared_init_en),
        .cfg_term_is_ce     (cfg_term_is_ce),
        .ctl                (ctl)
    );

    lcell_store u_store (
        .clk      (clk),
        .rst      (rst),
        .mode     (store_mode_e'(cfg_mode)),
        .preset   (cfg_preset),
        .init_req (ctl.init_req),
        .ce       (ctl.ce),
        .rise     (src_rise),
        .gate     (src_level),
        .d        (ctl.store_d),
        .q_view   (q_view)
    );

    assign cell_q = cfg_bypass ? ctl.xor_val : q_view;

    // R8 R9: an initialization request from either term forces the output at once
    a_r8_init_output: assert property (@(posedge clk) disable iff (rst)
        (!cfg_bypass && ((cfg_shared_init_en && shared_init) || (!cfg_term_is_ce && term_pt)))
        |-> (cell_q == cfg_preset));

    // R12: bypass shows the XOR of the logic input
    a_r12_bypass_out: assert property (@(posedge clk) disable iff (rst)
        cfg_bypass |-> (cell_q == (logic_in ^ cfg_invert)));

endmodule

// File: tb/logic_out_cell_test.sv
`timescale 1ns/1ps
module logic_out_cell_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] blk_clk;
    logic       shared_clk, term_clk, logic_in, pad_in, shared_init, term_pt;
    logic [2:0] cfg_clk_sel;
    logic [1:0] cfg_mode;
    logic       cfg_invert, cfg_pad_sel, cfg_bypass, cfg_preset;
    logic       cfg_shared_init_en, cfg_term_is_ce;
    logic       cell_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit m_q;
    bit m_prev;

    always #2 clk = ~clk;

    logic_out_cell uut (
        .clk(clk), .rst(rst), .blk_clk(blk_clk), .shared_clk(shared_clk),
        .term_clk(term_clk), .logic_in(logic_in), .pad_in(pad_in),
        .shared_init(shared_init), .term_pt(term_pt), .cfg_clk_sel(cfg_clk_sel),
        .cfg_mode(cfg_mode), .cfg_invert(cfg_invert), .cfg_pad_sel(cfg_pad_sel),
        .cfg_bypass(cfg_bypass), .cfg_preset(cfg_preset),
        .cfg_shared_init_en(cfg_shared_init_en), .cfg_term_is_ce(cfg_term_is_ce),
        .cell_q(cell_q)
    );

    function automatic bit src_of(int sel);
        case (sel)
            0, 1, 2, 3: return blk_clk[sel];
            4:          return shared_clk;
            5:          return term_clk;
            6:          return ~term_clk;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic string tag_now();
        if (cfg_bypass)                              return "R12";
        if (!cfg_term_is_ce && term_pt)              return "R9";
        if (cfg_shared_init_en && shared_init)       return "R8";
        if (cfg_clk_sel == 3'd7)                     return "R6";
        if (cfg_pad_sel)                             return "R11";
        if (cfg_term_is_ce)                          return "R10";
        if (cfg_mode == 2'd2)                        return "R5";
        if (cfg_mode == 2'd1)                        return "R4";
        if (cfg_invert)                              return "R2";
        return "R3 R7";
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: cell_q=%b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic rand_cfg();
        cfg_clk_sel        = 3'($urandom_range(0, 7));
        cfg_mode           = 2'($urandom_range(0, 3));
        cfg_invert         = 1'($urandom_range(0, 1));
        cfg_pad_sel        = ($urandom_range(0, 3) == 0);
        cfg_bypass         = ($urandom_range(0, 5) == 0);
        cfg_preset         = 1'($urandom_range(0, 1));
        cfg_shared_init_en = 1'($urandom_range(0, 1));
        cfg_term_is_ce     = 1'($urandom_range(0, 1));
    endtask

    task automatic rand_in();
        blk_clk     = 4'($urandom_range(0, 15));
        shared_clk  = 1'($urandom_range(0, 1));
        term_clk    = 1'($urandom_range(0, 1));
        logic_in    = 1'($urandom_range(0, 1));
        pad_in      = 1'($urandom_range(0, 1));
        shared_init = ($urandom_range(0, 7) == 0);
        term_pt     = cfg_term_is_ce ? 1'($urandom_range(0, 1)) : ($urandom_range(0, 7) == 0);
    endtask

    // one cycle: inputs already driven at the falling edge
    task automatic step();
        bit lvl, rise, d, init, ce, latch, exp, nxt;
        #1;
        lvl   = src_of(int'(cfg_clk_sel));
        rise  = lvl && !m_prev;
        d     = cfg_pad_sel ? pad_in : (logic_in ^ cfg_invert);
        init  = (cfg_shared_init_en && shared_init) || (!cfg_term_is_ce && term_pt);
        ce    = cfg_term_is_ce ? term_pt : 1'b1;
        latch = (cfg_mode == 2'd2);
        if (cfg_bypass)                 exp = logic_in ^ cfg_invert;
        else if (init)                  exp = cfg_preset;
        else if (latch && lvl && ce)    exp = d;
        else                            exp = m_q;
        check(tag_now(), cell_q, exp);
        if (init)                       nxt = cfg_preset;
        else if (latch)                 nxt = (lvl && ce) ? d : m_q;
        else if (rise && ce)            nxt = (cfg_mode == 2'd1) ? (m_q ^ d) : d;
        else                            nxt = m_q;
        @(posedge clk);
        m_q    = nxt;
        m_prev = lvl;
        @(negedge clk);
    endtask

    task automatic reset_check(bit pv);
        @(negedge clk);
        rst = 1'b1; cfg_preset = pv; cfg_bypass = 1'b0; cfg_mode = 2'd0;
        cfg_shared_init_en = 1'b0; cfg_term_is_ce = 1'b1; term_pt = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R1", cell_q, pv);
        rst = 1'b0;
        m_q = pv;
        m_prev = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        rand_cfg();
        rand_in();
        reset_check(1'b1);
        reset_check(1'b0);
        // R6: code 7 must hold through toggling sources
        @(negedge clk);
        cfg_clk_sel = 3'd7; cfg_mode = 2'd0; cfg_term_is_ce = 1'b1;
        for (int k = 0; k < 40; k++) begin
            rand_in();
            term_pt = 1'b1; shared_init = 1'b0;
            step();
        end
        for (int blk = 0; blk < 150; blk++) begin
            rand_cfg();
            for (int k = 0; k < 24; k++) begin
                rand_in();
                step();
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule